// File: doc/BRIEF.md
# Two-Level DMA Channel Issue Scheduler

This block decides which DMA channel may issue its next transfer. Each channel supplies three inputs: an enable, a request and a high/low priority flag. A channel is eligible when it is both enabled and requesting. The flag only changes the order in which channels get an issue slot. It does not change how the engine competes on the system bus.

Issue slots are handed out in rounds. A round first visits every eligible high-priority channel, in ascending index order. It then admits exactly one eligible low-priority channel, and a new round begins. The low-priority channel is chosen round-robin, so the search in each round starts just after the low channel that was granted last.

If no high-priority channel is eligible, the low channels are served back to back. If no low-priority channel is eligible, the high-priority sweep starts again at once. The grant is a registered one-hot vector. It is held until the engine pulses `accept`.

Top module: `dma_issue_sched`

## Requirements
- R1: `grant` has at most one bit set in every cycle. It is a register, so a decision taken from the inputs at one clock edge appears on `grant` just after that edge.
- R2: While a grant is shown and `accept` is low, the grant stays unchanged, as long as the granted channel's enable stays high. A new decision is taken at the edge where `accept` is high.
- R3: Within a round, eligible high-priority channels (`ch_high` bit = 1) are granted in ascending index order. Each high channel is granted at most once per round.
- R4: Once no eligible high-priority channel remains above the last one granted in the round, exactly one eligible low-priority channel (`ch_high` bit = 0) is granted. The next round then restarts the high sweep at index 0.
- R5: The low-priority search starts at the index after the last granted low channel and wraps from the top index to 0. After reset it starts at index 0.
- R6: With no eligible high-priority channel, low channels are granted on consecutive decisions. With no eligible low channel, the high sweep restarts at index 0 without an idle slot.
- R7: A channel whose enable was low at the deciding edge is never granted. A held grant is withdrawn at the edge after its enable drops, and a new decision is taken at that same edge.
- R8: When no channel is eligible at a deciding edge, `grant` becomes all zeros.
- R9: Synchronous reset clears the grant and the round state. The first round after reset starts at high index 0 and low index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | N_CH | Per-channel enable; a disabled channel is skipped |
| ch_request | input | N_CH | Per-channel transfer request |
| ch_high | input | N_CH | Per-channel priority flag, 1 = high |
| accept | input | 1 | The engine takes the currently shown grant |
| grant | output | N_CH | Registered one-hot issue grant, all zeros when idle |

## Verification
The hardest situation to reach from the ports is a round that ends early. This happens when the high-priority channels above the sweep position lose eligibility mid-round, so the single low slot must be admitted before the sweep has reached the top index. Enables are also dropped under a held grant in the same stretch. The bench reaches this by redrawing requests, priorities and enables every cycle while `accept` toggles at random, in addition to a fixed mixed pattern with a known grant order. A behavioural model that tracks the sweep index, the low rotation index and the held grant with plain integers predicts the grant on every clock.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  // Source of the pick taken at a deciding edge
  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_HIGH    = 2'd1,
    PICK_LOW     = 2'd2,
    PICK_RESTART = 2'd3
  } pick_src_e;
endpackage

// File: rtl/dma_sched_find.sv
// First set bit of vec at or after start; optional wrap-around.
module dma_sched_find #(
  parameter int N_CH = 8,
  parameter bit WRAP = 1'b0,
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int SW = IW + 1
) (
  input  logic [N_CH-1:0] vec,
  input  logic [SW-1:0]   start,
  output logic            found,
  output logic [IW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N_CH; k++) begin
      int p;
      p = int'(start) + k;
      if (WRAP && p >= N_CH) p = p - N_CH;
      if (!found && p < N_CH) begin
        if (vec[p[IW-1:0]]) begin
          found = 1'b1;
          idx   = p[IW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/dma_issue_sched.sv
module dma_issue_sched
  import dma_sched_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int SW = IW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] ch_enable,
  input  logic [N_CH-1:0] ch_request,
  input  logic [N_CH-1:0] ch_high,
  input  logic            accept,
  output logic [N_CH-1:0] grant
);
  logic [N_CH-1:0] elig, hi_vec, lo_vec;
  logic [SW-1:0]   hi_ptr;   // next high index to visit; N_CH = sweep done
  logic [IW-1:0]   lo_ptr;   // low round-robin search start

  logic            hc_found, hz_found, lo_found;
  logic [IW-1:0]   hc_idx, hz_idx, lo_idx;
  logic            free;
  pick_src_e       src;
  logic [IW-1:0]   pick_idx;

  assign elig   = ch_enable & ch_request;
  assign hi_vec = elig & ch_high;
  assign lo_vec = elig & ~ch_high;

  // high sweep continuing the current round
  dma_sched_find #(.N_CH(N_CH), .WRAP(1'b0)) u_hi_cur (
    .vec(hi_vec), .start(hi_ptr), .found(hc_found), .idx(hc_idx));
  // high sweep for a freshly started round
  dma_sched_find #(.N_CH(N_CH), .WRAP(1'b0)) u_hi_new (
    .vec(hi_vec), .start('0), .found(hz_found), .idx(hz_idx));
  // rotating low search
  dma_sched_find #(.N_CH(N_CH), .WRAP(1'b1)) u_lo (
    .vec(lo_vec), .start({1'b0, lo_ptr}), .found(lo_found), .idx(lo_idx));

  // a new decision is taken when idle, on accept, or when the held channel is disabled
  assign free = (grant == '0) || accept || ((grant & ch_enable) == '0);

  always_comb begin
    src      = PICK_NONE;
    pick_idx = '0;
    if (hc_found) begin
      src      = PICK_HIGH;
      pick_idx = hc_idx;
    end else if (lo_found) begin
      src      = PICK_LOW;
      pick_idx = lo_idx;
    end else if (hz_found) begin
      src      = PICK_RESTART;
      pick_idx = hz_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant  <= '0;
      hi_ptr <= '0;
      lo_ptr <= '0;
    end else if (free) begin
      grant <= '0;
      unique case (src)
        PICK_HIGH, PICK_RESTART: begin
          grant[pick_idx] <= 1'b1;
          hi_ptr          <= {1'b0, pick_idx} + SW'(1);
        end
        PICK_LOW: begin
          grant[pick_idx] <= 1'b1;
          hi_ptr          <= '0;
          lo_ptr          <= (pick_idx == IW'(N_CH - 1)) ? '0 : pick_idx + IW'(1);
        end
        default: hi_ptr <= '0;
      endcase
    end
  end

  // R1: single grant
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2: grant held without accept while the channel stays enabled
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !accept && (grant & ch_enable) != '0) |=> $stable(grant));

  // R7: only channels enabled at the previous edge hold a grant
  a_r7_enabled: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> (($past(ch_enable) & grant) != '0));

  // R8: nothing eligible at a deciding edge means no grant
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    ((elig == '0) && free) |=> (grant == '0));

  // R4: a low grant always restarts the high sweep at index 0
  a_r4_round_restart: assert property (@(posedge clk) disable iff (rst)
    (free && src == PICK_LOW) |=> (hi_ptr == '0));

  // R1: sweep position never exceeds the channel count
  a_r1_ptr_range: assert property (@(posedge clk) disable iff (rst)
    hi_ptr <= SW'(N_CH));
endmodule

// File: tb/dma_issue_sched_tb.sv
module dma_issue_sched_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ch_enable = '0, ch_request = '0, ch_high = '0;
  logic         accept = 1'b0;
  logic [N-1:0] grant;

  int compared = 0, mismatched = 0;
  string tag = "R9";
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dma_issue_sched #(.N_CH(N)) u_dut (
    .clk(clk), .rst(rst), .ch_enable(ch_enable), .ch_request(ch_request),
    .ch_high(ch_high), .accept(accept), .grant(grant));

  // behavioural reference: held index, sweep position, low rotation start
  int mg = -1, mh = 0, ml = 0;

  always @(posedge clk) begin
    if (rst) begin
      mg = -1; mh = 0; ml = 0;
    end else if (mg < 0 || accept || !ch_enable[mg]) begin
      int pick;
      pick = -1;
      for (int i = mh; i < N; i++)
        if (pick < 0 && ch_enable[i] && ch_request[i] && ch_high[i]) pick = i;
      if (pick >= 0) begin
        mh = pick + 1;
      end else begin
        for (int k = 0; k < N; k++) begin
          int j;
          j = (ml + k) % N;
          if (pick < 0 && ch_enable[j] && ch_request[j] && !ch_high[j]) pick = j;
        end
        if (pick >= 0) begin
          mh = 0;
          ml = (pick + 1) % N;
        end else begin
          for (int i = 0; i < N; i++)
            if (pick < 0 && ch_enable[i] && ch_request[i] && ch_high[i]) pick = i;
          mh = (pick >= 0) ? pick + 1 : 0;
        end
      end
      mg = pick;
    end
  end

  function automatic logic [N-1:0] model_vec();
    return (mg < 0) ? '0 : (N'(1) << mg);
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (grant !== model_vec()) begin
        mismatched++;
        $display("FAIL %s: grant actual %b expected %b", tag, grant, model_vec());
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int seq [12] = '{1, 3, 0, 1, 3, 2, 1, 3, 5, 1, 3, 0};
    repeat (3) @(negedge clk);
    // R9: reset state
    compared++;
    if (grant !== '0) begin
      mismatched++;
      $display("FAIL R9: grant actual %b expected 0", grant);
    end

    // R3 R4 R5: fixed mix, highs {1,3}, lows {0,2,5}
    tag = "R3 R4 R5";
    ch_enable = '1; ch_request = 8'b0010_1111; ch_high = 8'b0000_1010; accept = 1'b1;
    rst = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      compared++;
      if (grant !== (N'(1) << seq[k])) begin
        mismatched++;
        $display("FAIL R3 R4 R5: step %0d grant actual %b expected %b", k, grant, N'(1) << seq[k]);
      end
    end

    // R2: hold without accept
    tag = "R2";
    accept = 1'b0;
    @(negedge clk);
    begin
      logic [N-1:0] held;
      held = grant;
      repeat (5) @(negedge clk);
      compared++;
      if (grant !== held) begin
        mismatched++;
        $display("FAIL R2: grant actual %b expected %b", grant, held);
      end
    end

    // R6: only low channels, served back to back
    tag = "R6";
    ch_high = '0; ch_request = 8'b1001_0110; accept = 1'b1;
    repeat (2000) @(negedge clk);
    // R6: only high channels, sweep restarts
    ch_high = '1; ch_request = 8'b0110_0101;
    repeat (500) @(negedge clk);
    for (int c = 0; c < 1500; c++) begin
      ch_request = N'($urandom);
      accept = $urandom_range(0, 1) == 1;
      @(negedge clk);
    end

    // R1 R2 R7: random mix with enables toggling
    tag = "R1 R2 R7";
    for (int c = 0; c < 6000; c++) begin
      ch_enable  = N'($urandom) | N'($urandom);
      ch_request = N'($urandom);
      ch_high    = N'($urandom);
      accept     = $urandom_range(0, 2) != 0;
      @(negedge clk);
    end

    // R7: held grant with its enable removed
    tag = "R7";
    ch_enable = '1; ch_request = '1; ch_high = 8'b0000_1111; accept = 1'b0;
    repeat (3) @(negedge clk);
    ch_enable = ~grant;
    @(negedge clk);
    compared++;
    if ((grant & ~ch_enable) != '0 || grant == '0) begin
      mismatched++;
      $display("FAIL R7: grant actual %b expected a bit within %b", grant, ch_enable);
    end

    // R8: nothing eligible
    tag = "R8";
    ch_request = '0; accept = 1'b1;
    repeat (3) @(negedge clk);
    compared++;
    if (grant !== '0) begin
      mismatched++;
      $display("FAIL R8: grant actual %b expected 0", grant);
    end
    ch_enable = '0; ch_request = '1;
    repeat (3) @(negedge clk);
    compared++;
    if (grant !== '0) begin
      mismatched++;
      $display("FAIL R8: grant actual %b expected 0 with all disabled", grant);
    end

    // R9: reset mid-run
    tag = "R9";
    ch_enable = '1;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    compared++;
    if (grant !== '0) begin
      mismatched++;
      $display("FAIL R9: grant actual %b expected 0", grant);
    end
    rst = 1'b0;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule